// File: doc/BRIEF.md
# Iterative AES-256 Block Cipher Core

This block encrypts or decrypts one 128-bit block under a 256-bit key, one cipher round per clock cycle. Software or a mode engine first loads a key. The core then expands the fifteen round keys into a local table, one round key per cycle. After that, any number of blocks can be processed in either direction. The direction is chosen per block, so one key serves both encryption and decryption.

Blocks enter through a valid/ready handshake. A block is taken on a rising clock edge when `blk_valid` and `blk_ready` are both high. `blk_ready` is low while a block is in flight, while the key table is being built, and in any cycle where `key_load` is high. A producer must therefore hold `blk_valid` and its data until the handshake completes. The result side has no back-pressure. `res_valid` is a one-cycle pulse, and `res_data` keeps the last result until the next one replaces it, so a slow consumer can capture it later.

Top module: `aes256_iter_core`

## Requirements
- R1: After reset, `busy` and `res_valid` are 0, `blk_ready` is 1 and `res_data` is all zeros.
- R2: `key_load` is accepted only when `busy` is 0. After the accepting edge, `busy` is high for exactly 13 cycles while round keys 2..14 are built. `blk_ready` is 0 in any cycle where `key_load` is high.
- R3: Encryption gives the standard AES-256 ciphertext. State byte n (0..15) is `blk_in[127-8n -: 8]`, column c holds bytes 4c..4c+3, and key byte 0 is `key_in[255:248]`.
- R4: With `decrypt`=1 the core applies the inverse cipher, so decrypting a ciphertext under the same key returns the plaintext.
- R5: After the accepting edge, `busy` is high for exactly 15 cycles: one cycle for the initial key addition plus 14 round cycles.
- R6: `res_valid` rises at the same edge that clears `busy`, which is the 15th edge after acceptance, and lasts exactly one cycle.
- R7: `blk_valid` while a block is in flight has no effect: no extra result appears, and the running result is unchanged.
- R8: `key_load` while `busy` is high is ignored, and the key in use stays the old one.
- R9: `res_data` holds its value from one `res_valid` pulse until the next.
- R10: The direction is sampled at acceptance. Toggling `decrypt` during a block has no effect on that block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_load | input | 1 | Load strobe for a new key |
| key_in | input | 256 | Cipher key, byte 0 in the top bits |
| blk_valid | input | 1 | Input block valid |
| blk_ready | output | 1 | Core can accept a block |
| decrypt | input | 1 | 1 selects the inverse cipher for the offered block |
| blk_in | input | 128 | Input block, byte 0 in the top bits |
| res_data | output | 128 | Last result, held |
| res_valid | output | 1 | One-cycle pulse when a new result is in `res_data` |
| busy | output | 1 | Block in flight or key table being built |

## Verification
The bench checks the published 256-bit-key known answers in both directions. A mistake in byte ordering, the S-box, the row rotation direction or the key schedule's alternating substitution would produce a wrong ciphertext there. Random keys and blocks are compared against an independent table-driven model.

Latency is counted edge by edge. A core that skipped the initial key addition, or added a spare round, would show 14 or 16 busy cycles, or a pulse longer than one cycle.

During one block, the bench offers a different block, a flipped direction and a new key all at once. A core that did not gate these would emit a second pulse, return a corrupted result, or encrypt the next block under the new key.

// File: rtl/aes_core_pkg.sv
package aes_core_pkg;
  localparam int NK     = 8;
  localparam int NB     = 4;
  localparam int NR     = 14;
  localparam int WORD_W = 32;
  localparam int BLK_W  = NB * WORD_W;
  localparam int KEY_W  = NK * WORD_W;
  localparam int NBYTES = BLK_W / 8;

  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = gf_dbl(x);
    end
    return p;
  endfunction

  // a^254 by a square-and-multiply chain; maps 0 to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] t;
    t = a;
    for (int i = 0; i < 6; i++) begin
      t = gf_mul(t, t);
      t = gf_mul(t, a);
    end
    return gf_mul(t, t);
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  function automatic logic [7:0] affine_fwd(input logic [7:0] b);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] affine_rev(input logic [7:0] b);
    return rotl8(b, 1) ^ rotl8(b, 3) ^ rotl8(b, 6) ^ 8'h05;
  endfunction

  function automatic logic [BLK_W-1:0] rot_rows(input logic [BLK_W-1:0] s, input logic inv);
    logic [BLK_W-1:0] o;
    int src;
    o = '0;
    for (int c = 0; c < NB; c++) begin
      for (int r = 0; r < 4; r++) begin
        src = inv ? ((c - r + NB) % NB) : ((c + r) % NB);
        o[BLK_W-1-8*(4*c+r) -: 8] = s[BLK_W-1-8*(4*src+r) -: 8];
      end
    end
    return o;
  endfunction

  function automatic logic [BLK_W-1:0] mix_cols(input logic [BLK_W-1:0] s, input logic inv);
    logic [BLK_W-1:0] o;
    logic [7:0] a [4];
    logic [7:0] k0, k1, k2, k3;
    k0 = inv ? 8'h0e : 8'h02;
    k1 = inv ? 8'h0b : 8'h03;
    k2 = inv ? 8'h0d : 8'h01;
    k3 = inv ? 8'h09 : 8'h01;
    o = '0;
    for (int c = 0; c < NB; c++) begin
      for (int r = 0; r < 4; r++) a[r] = s[BLK_W-1-8*(4*c+r) -: 8];
      for (int r = 0; r < 4; r++) begin
        o[BLK_W-1-8*(4*c+r) -: 8] = gf_mul(a[r], k0) ^ gf_mul(a[(r+1)%4], k1)
                                  ^ gf_mul(a[(r+2)%4], k2) ^ gf_mul(a[(r+3)%4], k3);
      end
    end
    return o;
  endfunction
endpackage

// File: rtl/aes_sbox.sv
module aes_sbox (
  input  logic [7:0] din,
  input  logic       inv,
  output logic [7:0] dout
);
  import aes_core_pkg::*;

  logic [7:0] pre, mid;

  // One shared field inverter serves both directions
  always_comb begin
    pre  = inv ? affine_rev(din) : din;
    mid  = gf_inv(pre);
    dout = inv ? mid : affine_fwd(mid);
  end
endmodule

// File: rtl/aes_round.sv
module aes_round
  import aes_core_pkg::*;
(
  input  logic [BLK_W-1:0] st,
  input  logic [BLK_W-1:0] rkey,
  input  logic             dec,
  input  logic             last,
  output logic [BLK_W-1:0] nxt
);
  logic [BLK_W-1:0] sb_in, sb_out, enc_sr, enc_mc, dec_ak;

  assign sb_in = dec ? rot_rows(st, 1'b1) : st;

  for (genvar n = 0; n < NBYTES; n++) begin : g_sub
    aes_sbox u_sb (
      .din  (sb_in[BLK_W-1-8*n -: 8]),
      .inv  (dec),
      .dout (sb_out[BLK_W-1-8*n -: 8])
    );
  end

  always_comb begin
    enc_sr = rot_rows(sb_out, 1'b0);
    enc_mc = last ? enc_sr : mix_cols(enc_sr, 1'b0);
    dec_ak = sb_out ^ rkey;
    if (dec) nxt = last ? dec_ak : mix_cols(dec_ak, 1'b1);
    else     nxt = enc_mc ^ rkey;
  end
endmodule

// File: rtl/aes_key_sched.sv
module aes_key_sched
  import aes_core_pkg::*;
#(
  parameter int ROUNDS = NR,
  localparam int IDX_W = $clog2(ROUNDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [KEY_W-1:0] key,
  output logic             expanding,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [BLK_W-1:0] rd_key
);
  logic [BLK_W-1:0] rk [0:ROUNDS];
  logic [BLK_W-1:0] prv0, prv1, grp;
  logic [IDX_W-1:0] g;
  logic [7:0]       rcon;
  logic [31:0]      sw_in, sw_out, mix_w;
  logic             even_g;

  assign even_g = ~g[0];
  // even groups start at a multiple of eight words: rotate and add round constant
  assign sw_in  = even_g ? {prv1[23:0], prv1[31:24]} : prv1[31:0];

  for (genvar b = 0; b < 4; b++) begin : g_sw
    aes_sbox u_sb (
      .din  (sw_in[31-8*b -: 8]),
      .inv  (1'b0),
      .dout (sw_out[31-8*b -: 8])
    );
  end

  always_comb begin
    mix_w = sw_out ^ (even_g ? {rcon, 24'h0} : 32'h0);
    grp[127:96] = prv0[127:96] ^ mix_w;
    grp[95:64]  = prv0[95:64]  ^ grp[127:96];
    grp[63:32]  = prv0[63:32]  ^ grp[95:64];
    grp[31:0]   = prv0[31:0]   ^ grp[63:32];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      expanding <= 1'b0;
      g         <= '0;
      rcon      <= 8'h01;
    end else if (load) begin
      expanding <= 1'b1;
      g         <= IDX_W'(2);
      rcon      <= 8'h01;
    end else if (expanding) begin
      if (g == IDX_W'(ROUNDS)) expanding <= 1'b0;
      else                     g <= g + 1'b1;
      if (even_g) rcon <= gf_dbl(rcon);
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      rk[0] <= key[KEY_W-1 -: BLK_W];
      rk[1] <= key[BLK_W-1:0];
      prv0  <= key[KEY_W-1 -: BLK_W];
      prv1  <= key[BLK_W-1:0];
    end else if (expanding) begin
      rk[g] <= grp;
      prv0  <= prv1;
      prv1  <= grp;
    end
  end

  assign rd_key = rk[rd_idx];

  assert_load_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> expanding);
  assert_group_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expanding |-> (g >= IDX_W'(2) && g <= IDX_W'(ROUNDS)));
  assert_expand_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (expanding && !load && g == IDX_W'(ROUNDS)) |=> !expanding);
endmodule

// File: rtl/aes256_iter_core.sv
module aes256_iter_core
  import aes_core_pkg::*;
#(
  parameter int ROUNDS = NR,
  localparam int IDX_W = $clog2(ROUNDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_load,
  input  logic [KEY_W-1:0] key_in,
  input  logic             blk_valid,
  output logic             blk_ready,
  input  logic             decrypt,
  input  logic [BLK_W-1:0] blk_in,
  output logic [BLK_W-1:0] res_data,
  output logic             res_valid,
  output logic             busy
);
  logic             run, dec_q, kx_busy, key_go, accept, last;
  logic [IDX_W-1:0] rnd, rk_idx;
  logic [BLK_W-1:0] st, rkey, nxt, res_q;
  logic             res_v;

  assign busy      = run | kx_busy;
  assign blk_ready = ~busy & ~key_load;
  assign key_go    = key_load & ~busy;
  assign accept    = blk_valid & blk_ready;
  assign last      = (rnd == IDX_W'(ROUNDS));
  assign rk_idx    = dec_q ? (IDX_W'(ROUNDS) - rnd) : rnd;
  assign res_data  = res_q;
  assign res_valid = res_v;

  aes_key_sched #(.ROUNDS(ROUNDS)) u_ks (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (key_go),
    .key       (key_in),
    .expanding (kx_busy),
    .rd_idx    (rk_idx),
    .rd_key    (rkey)
  );

  aes_round u_rnd (
    .st   (st),
    .rkey (rkey),
    .dec  (dec_q),
    .last (last),
    .nxt  (nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      dec_q <= 1'b0;
      rnd   <= '0;
      st    <= '0;
      res_q <= '0;
      res_v <= 1'b0;
    end else begin
      res_v <= 1'b0;
      if (accept) begin
        st    <= blk_in;
        dec_q <= decrypt;
        run   <= 1'b1;
        rnd   <= '0;
      end else if (run) begin
        if (rnd == '0) st <= st ^ rkey;
        else           st <= nxt;
        if (last) begin
          run   <= 1'b0;
          res_v <= 1'b1;
          res_q <= nxt;
        end else begin
          rnd <= rnd + 1'b1;
        end
      end
    end
  end

  assert_accept_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  assert_round_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> rnd <= IDX_W'(ROUNDS));
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !busy);
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> (rnd == $past(rnd) + 1'b1 || rnd == IDX_W'(ROUNDS)));
  assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_data));
  assert_dir_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(dec_q));
endmodule

// File: tb/sim_aes256_iter_core.sv
`timescale 1ns/1ps
module sim_aes256_iter_core;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         key_load = 1'b0;
  logic [255:0] key_in = '0;
  logic         blk_valid = 1'b0;
  logic         blk_ready;
  logic         decrypt = 1'b0;
  logic [127:0] blk_in = '0;
  logic [127:0] res_data;
  logic         res_valid;
  logic         busy;

  int  total = 0;
  int  bad = 0;
  bit  ended = 1'b0;
  logic [7:0] fsb [256];
  logic [7:0] rsb [256];

  always #2 clk = ~clk;

  aes256_iter_core u0 (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
    .blk_valid(blk_valid), .blk_ready(blk_ready), .decrypt(decrypt),
    .blk_in(blk_in), .res_data(res_data), .res_valid(res_valid), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ml(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  // S-box tables built by walking the multiplicative group with generator 3
  task automatic build_tables();
    logic [7:0] p = 8'h01, q = 8'h01, x;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b00};
      q = q ^ {q[3:0], 4'h0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
      fsb[p] = x ^ 8'h63;
    end while (p != 8'h01);
    fsb[0] = 8'h63;
    for (int i = 0; i < 256; i++) rsb[fsb[i]] = 8'(i);
  endtask

  function automatic logic [127:0] ref_aes(input logic [255:0] k, input logic [127:0] d,
                                           input bit inv);
    logic [31:0] w [60];
    logic [7:0]  m [4][4];
    logic [7:0]  t [4][4];
    logic [7:0]  a [4];
    logic [7:0]  rc = 8'h01;
    logic [31:0] tmp;
    logic [127:0] o;
    for (int i = 0; i < 8; i++) w[i] = k[255-32*i -: 32];
    for (int i = 8; i < 60; i++) begin
      tmp = w[i-1];
      if (i % 8 == 0) begin
        tmp = {fsb[tmp[23:16]], fsb[tmp[15:8]], fsb[tmp[7:0]], fsb[tmp[31:24]]} ^ {rc, 24'h0};
        rc = ml(rc, 8'h02);
      end else if (i % 8 == 4) begin
        tmp = {fsb[tmp[31:24]], fsb[tmp[23:16]], fsb[tmp[15:8]], fsb[tmp[7:0]]};
      end
      w[i] = w[i-8] ^ tmp;
    end
    for (int c = 0; c < 4; c++) for (int r = 0; r < 4; r++) m[r][c] = d[127-8*(4*c+r) -: 8];
    for (int s = 0; s <= 14; s++) begin
      int rr = inv ? 14 - s : s;
      if (s > 0) begin
        if (!inv) begin
          for (int r = 0; r < 4; r++) for (int c = 0; c < 4; c++) t[r][c] = fsb[m[r][(c+r)%4]];
        end else begin
          for (int r = 0; r < 4; r++) for (int c = 0; c < 4; c++) t[r][(c+r)%4] = rsb[m[r][c]];
        end
        if (!inv && s < 14) begin
          for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) a[r] = t[r][c];
            for (int r = 0; r < 4; r++)
              t[r][c] = ml(a[r], 8'h02) ^ ml(a[(r+1)%4], 8'h03) ^ a[(r+2)%4] ^ a[(r+3)%4];
          end
        end
        m = t;
      end
      for (int c = 0; c < 4; c++) for (int r = 0; r < 4; r++) m[r][c] ^= w[4*rr+c][31-8*r -: 8];
      if (inv && s > 0 && s < 14) begin
        for (int c = 0; c < 4; c++) begin
          for (int r = 0; r < 4; r++) a[r] = m[r][c];
          for (int r = 0; r < 4; r++)
            m[r][c] = ml(a[r], 8'h0e) ^ ml(a[(r+1)%4], 8'h0b) ^ ml(a[(r+2)%4], 8'h0d)
                    ^ ml(a[(r+3)%4], 8'h09);
        end
      end
    end
    for (int c = 0; c < 4; c++) for (int r = 0; r < 4; r++) o[127-8*(4*c+r) -: 8] = m[r][c];
    return o;
  endfunction

  task automatic load_key(input logic [255:0] k);
    int n = 0;
    key_load = 1'b1;
    key_in = k;
    #0;
    chk(blk_ready == 1'b0, "R2", "ready while key_load", 256'(blk_ready), 256'(0));
    @(negedge clk);
    key_load = 1'b0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk(n == 13, "R2", "key expansion busy cycles", 256'(n), 256'(13));
  endtask

  // poke >= 0 offers a foreign block, flipped direction and new key at that cycle
  task automatic run_block(input bit dec, input logic [127:0] din, input logic [255:0] cur_key,
                           input int poke, output logic [127:0] res);
    int n = 0;
    int nb = 0;
    blk_valid = 1'b1;
    blk_in = din;
    decrypt = dec;
    @(negedge clk);
    blk_valid = 1'b0;
    while (!res_valid && n < 100) begin
      if (busy) nb++;
      if (n == poke) begin
        blk_valid = 1'b1; blk_in = ~din; decrypt = ~dec; key_load = 1'b1; key_in = ~cur_key;
      end else begin
        blk_valid = 1'b0; decrypt = dec; key_load = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    blk_valid = 1'b0; key_load = 1'b0;
    chk(n == 15, "R6", "edges to result pulse", 256'(n), 256'(15));
    chk(nb == 15, "R5", "busy cycles per block", 256'(nb), 256'(15));
    chk(busy == 1'b0, "R6", "busy at pulse", 256'(busy), 256'(0));
    res = res_data;
    @(negedge clk);
    chk(res_valid == 1'b0, "R6", "pulse width", 256'(res_valid), 256'(0));
    if (poke >= 0)
      chk(busy == 1'b0, "R8", "no late key load", 256'(busy), 256'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [255:0] k1, k2, kr;
    logic [127:0] r, e, p, r2;
    void'($urandom(32'd20240517));
    build_tables();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", 256'(busy), 256'(0));
    chk(res_valid == 1'b0, "R1", "valid after reset", 256'(res_valid), 256'(0));
    chk(blk_ready == 1'b1, "R1", "ready after reset", 256'(blk_ready), 256'(1));
    chk(res_data == '0, "R1", "data after reset", 256'(res_data), 256'(0));

    // known answers
    k1 = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
    load_key(k1);
    run_block(1'b0, 128'h00112233445566778899aabbccddeeff, k1, -1, r);
    chk(r == 128'h8ea2b7ca516745bfeafc49904b496089, "R3", "known answer 1 enc",
        256'(r), 256'(128'h8ea2b7ca516745bfeafc49904b496089));
    run_block(1'b1, 128'h8ea2b7ca516745bfeafc49904b496089, k1, -1, r);
    chk(r == 128'h00112233445566778899aabbccddeeff, "R4", "known answer 1 dec",
        256'(r), 256'(128'h00112233445566778899aabbccddeeff));
    k2 = 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;
    load_key(k2);
    run_block(1'b0, 128'h6bc1bee22e409f96e93d7e117393172a, k2, -1, r);
    chk(r == 128'hf3eed1bdb5d2a03c064b5a7e3db181f8, "R3", "known answer 2 enc",
        256'(r), 256'(128'hf3eed1bdb5d2a03c064b5a7e3db181f8));
    run_block(1'b1, 128'hf3eed1bdb5d2a03c064b5a7e3db181f8, k2, -1, r);
    chk(r == 128'h6bc1bee22e409f96e93d7e117393172a, "R4", "known answer 2 dec",
        256'(r), 256'(128'h6bc1bee22e409f96e93d7e117393172a));

    // hold of result while idle
    repeat (7) @(negedge clk);
    chk(res_data == 128'h6bc1bee22e409f96e93d7e117393172a, "R9", "result held while idle",
        256'(res_data), 256'(128'h6bc1bee22e409f96e93d7e117393172a));

    // disturbances during a block, at the first, a middle and the last busy cycle
    foreach (e[i]) ;
    for (int pk = 0; pk < 15; pk += 7) begin
      p = {$urandom, $urandom, $urandom, $urandom};
      e = ref_aes(k2, p, 1'b0);
      run_block(1'b0, p, k2, pk, r);
      chk(r == e, "R7", "foreign block during run", 256'(r), 256'(e));
      chk(r == e, "R10", "direction flip during run", 256'(r), 256'(e));
      run_block(1'b1, e, k2, pk, r);
      chk(r == p, "R10", "direction flip during decrypt", 256'(r), 256'(p));
      run_block(1'b0, 128'h6bc1bee22e409f96e93d7e117393172a, k2, -1, r);
      chk(r == 128'hf3eed1bdb5d2a03c064b5a7e3db181f8, "R8", "key kept after busy load",
          256'(r), 256'(128'hf3eed1bdb5d2a03c064b5a7e3db181f8));
    end

    // result hold across the next block's run
    r2 = res_data;
    blk_valid = 1'b1; blk_in = 128'h0; decrypt = 1'b0;
    @(negedge clk);
    blk_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk(res_data == r2, "R9", "result held during next run", 256'(res_data), 256'(r2));
    while (!res_valid) @(negedge clk);
    @(negedge clk);

    // random keys and blocks
    for (int kk = 0; kk < 6; kk++) begin
      kr = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      if (kk == 0) kr = '0;
      if (kk == 1) kr = '1;
      load_key(kr);
      for (int b = 0; b < 3; b++) begin
        p = {$urandom, $urandom, $urandom, $urandom};
        if (b == 0 && kk == 2) p = '1;
        e = ref_aes(kr, p, 1'b0);
        run_block(1'b0, p, kr, -1, r);
        chk(r == e, "R3", "random encrypt", 256'(r), 256'(e));
        e = ref_aes(kr, p, 1'b1);
        run_block(1'b1, p, kr, -1, r);
        chk(r == e, "R4", "random decrypt", 256'(r), 256'(e));
        run_block(1'b0, r, kr, -1, r2);
        chk(r2 == p, "R4", "decrypt then encrypt round trip", 256'(r2), 256'(p));
      end
    end

    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule